// File: doc/BRIEF.md
# Three-Tap Fixed-Point Low-Pass FIR Filter

This block is a direct-form low-pass FIR filter with three taps. When the input-valid strobe is high, it accepts one unsigned fixed-point sample in that clock cycle. One clock later it presents y(n) = h0·x(n) + h1·x(n-1) + h2·x(n-2) together with an output-valid strobe. The coefficients are fixed and symmetric: h0 = h2 = 41/128 and h1 = 45/128. Each coefficient is realised as a constant shift-and-add multiplier. A two-stage register chain holds the past samples. Plain carry adders sum the three products.

Input samples use 4 integer bits and 5 fractional bits. Output samples use 4 integer bits and 7 fractional bits. Each product is truncated to 7 fractional bits before the sum, so the arithmetic is exact and easy to model bit for bit. When no valid sample arrives, the filter keeps its history and its last result.

Top module: `fir3_filter`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, out_valid is 0 and out_sample is 0.
- R2: For a valid input with raw integer codes X0 = x(n), X1 = x(n-1), X2 = x(n-2), the output code is floor(41·X0/32) + floor(45·X1/32) + floor(41·X2/32). Input bits 8:5 hold the integer part and bits 4:0 the fraction. Output bits 10:7 hold the integer part and bits 6:0 the fraction.
- R3: out_valid is high exactly in the cycle after a cycle with in_valid high. The new out_sample appears in that same cycle.
- R4: A cycle with in_valid low leaves the stored history and out_sample unchanged, so the sample value it carries has no effect.
- R5: After reset, both past samples read as zero. The first output is floor(41·X0/32), and the second output ignores x(n-2).
- R6: A single input of 1.0 (code 32) surrounded by zeros gives the output codes 41, 45, 41 and then 0, which is a symmetric impulse response.
- R7: A full-scale input (code 511) held for three or more samples gives output code 2026. No input sequence can overflow the 11-bit output.
- R8: A ramp of 1.0, 2.0, 3.0 … after reset gives the output codes 41, 127 and 254 (about 0.320, 0.992 and 1.984) for the first three samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks in_sample as a new sample in this cycle |
| in_sample | input | 9 | Unsigned input sample, 4.5 fixed point |
| out_valid | output | 1 | Pulses one cycle after each accepted sample |
| out_sample | output | 11 | Filter result, 4.7 fixed point; held between samples |

## Verification
The main path is tried with several kinds of input. A lone 1.0 sample among zeros separates the three tap weights and shows the symmetry. A ramp from reset shows the zero-filled history and matches the known start values. A held full-scale input reaches the largest possible result and would expose any lost carry. Random samples with random gaps in valid check that truncation happens per product, and that idle cycles neither shift the history nor alter the held output. A reset in the middle of a run shows that the old history is really cleared.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

    localparam int NTAPS     = 3;
    localparam int IN_W      = 9;
    localparam int IN_FRAC   = 5;
    localparam int OUT_W     = 11;
    localparam int OUT_FRAC  = 7;
    localparam int COEF_FRAC = 7;

    // Quantized coefficients in units of 2**-COEF_FRAC, tap 0 first.
    localparam int unsigned TAP_COEF [NTAPS] = '{41, 45, 41};

    localparam int PROD_SHIFT = IN_FRAC + COEF_FRAC - OUT_FRAC;

    typedef logic [IN_W-1:0]  sample_t;
    typedef logic [OUT_W-1:0] result_t;

    typedef struct packed {
        logic    valid;
        result_t value;
    } out_beat_t;

    // Largest reachable output code for an all-ones input of width in_w.
    function automatic int unsigned peak_output(int in_w);
        int unsigned s;
        s = 0;
        for (int k = 0; k < NTAPS; k++) begin
            s = s + ((((1 << in_w) - 1) * TAP_COEF[k]) >> PROD_SHIFT);
        end
        return s;
    endfunction

endpackage

// File: rtl/fir3_delay_line.sv
module fir3_delay_line #(
    parameter int W     = 9,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] taps [DEPTH]
);
    localparam int STAGES = DEPTH - 1;

    logic [W-1:0] stage_q [STAGES];

    assign taps[0] = din;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stage_d;
        if (i == 0) begin : g_first
            assign stage_d = din;
        end else begin : g_rest
            assign stage_d = stage_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else if (shift_en) begin
                stage_q[i] <= stage_d;
            end
        end

        assign taps[i+1] = stage_q[i];
    end

endmodule

// File: rtl/fir3_const_mult.sv
module fir3_const_mult #(
    parameter int          IN_W   = 9,
    parameter int          OUT_W  = 11,
    parameter int unsigned COEF   = 41,
    parameter int          COEF_W = 7,
    parameter int          SHIFT  = 5
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] p
);
    localparam int ACC_W = IN_W + COEF_W;

    logic [ACC_W-1:0] acc;

    // One shifted copy of x for every set bit of the constant.
    always_comb begin
        acc = '0;
        for (int b = 0; b < COEF_W; b++) begin
            if (COEF[b]) begin
                acc = acc + (ACC_W'(x) << b);
            end
        end
    end

    // Drop the extra fractional bits (truncation toward zero).
    assign p = OUT_W'(acc >> SHIFT);

endmodule

// File: rtl/fir3_sum.sv
module fir3_sum #(
    parameter int W = 11,
    parameter int N = 3
) (
    input  logic [W-1:0] terms [N],
    output logic [W-1:0] total
);
    always_comb begin
        total = '0;
        for (int k = 0; k < N; k++) begin
            total = total + terms[k];
        end
    end

endmodule

// File: rtl/fir3_filter.sv
module fir3_filter
    import fir3_pkg::*;
#(
    parameter int IN_W     = fir3_pkg::IN_W,
    parameter int OUT_W    = fir3_pkg::OUT_W,
    parameter int IN_FRAC  = fir3_pkg::IN_FRAC,
    parameter int OUT_FRAC = fir3_pkg::OUT_FRAC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sample,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_sample
);
    localparam int SHIFT = IN_FRAC + COEF_FRAC - OUT_FRAC;

    logic [IN_W-1:0]  taps  [NTAPS];
    logic [OUT_W-1:0] prods [NTAPS];
    logic [OUT_W-1:0] sum;
    out_beat_t        beat_q;

    fir3_delay_line #(
        .W     (IN_W),
        .DEPTH (NTAPS)
    ) u_delay (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_sample),
        .taps     (taps)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        fir3_const_mult #(
            .IN_W   (IN_W),
            .OUT_W  (OUT_W),
            .COEF   (TAP_COEF[k]),
            .COEF_W (COEF_FRAC),
            .SHIFT  (SHIFT)
        ) u_mult (
            .x (taps[k]),
            .p (prods[k])
        );
    end

    fir3_sum #(
        .W (OUT_W),
        .N (NTAPS)
    ) u_sum (
        .terms (prods),
        .total (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= in_valid;
            if (in_valid) begin
                beat_q.value <= sum;
            end
        end
    end

    assign out_valid  = beat_q.valid;
    assign out_sample = beat_q.value;

endmodule

// File: rtl/fir3_filter_chk.sv
module fir3_filter_chk #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_sample
);
    localparam int unsigned PEAK = fir3_pkg::peak_output(IN_W);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    a_r3_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r4_idle_holds_output: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    a_r7_within_peak: assert property (@(posedge clk) disable iff (rst)
        32'(out_sample) <= PEAK);

endmodule

bind fir3_filter fir3_filter_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/fir3_filter_tb.sv
module fir3_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 9;
    localparam int OUT_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_sample = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_sample;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench-side history and expected output.
    int hist1 = 0;
    int hist2 = 0;
    int exp_y = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir3_filter u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic int model_y(int x0, int x1, int x2);
        return ((41 * x0) >> 5) + ((45 * x1) >> 5) + ((41 * x2) >> 5);
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 data in reset", int'(out_sample), 0);
        rst = 1'b0;
        hist1 = 0;
        hist2 = 0;
        exp_y = 0;
        @(posedge clk);
        #1;
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 data after reset", int'(out_sample), 0);
    endtask

    // Drive one cycle, then sample just after the next edge.
    task automatic step(bit v, int d, string req);
        in_valid  = v;
        in_sample = IN_W'(d);
        @(posedge clk);
        #1;
        if (v) begin
            exp_y = model_y(d, hist1, hist2);
            hist2 = hist1;
            hist1 = d;
        end
        check({req, " valid"}, int'(out_valid), int'(v));
        check({req, " data"}, int'(out_sample), exp_y);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        do_reset();

        // R8 ramp from reset, with fixed first values.
        for (int i = 1; i <= 9; i++) begin
            step(1'b1, i * 32, "R8 ramp");
            if (i == 1) check("R8 ramp first", int'(out_sample), 41);
            if (i == 2) check("R8 ramp second", int'(out_sample), 127);
            if (i == 3) check("R8 ramp third", int'(out_sample), 254);
        end

        // R6 impulse of 1.0 between zeros.
        for (int i = 0; i < 3; i++) step(1'b1, 0, "R6 flush");
        step(1'b1, 32, "R6 impulse");
        check("R6 tap0", int'(out_sample), 41);
        step(1'b1, 0, "R6 impulse");
        check("R6 tap1", int'(out_sample), 45);
        step(1'b1, 0, "R6 impulse");
        check("R6 tap2", int'(out_sample), 41);
        step(1'b1, 0, "R6 impulse");
        check("R6 tail", int'(out_sample), 0);

        // R7 full scale held.
        for (int i = 0; i < 4; i++) step(1'b1, 511, "R7 full scale");
        check("R7 peak", int'(out_sample), 2026);

        // R4 idle cycles with changing data have no effect.
        for (int i = 0; i < 5; i++) step(1'b0, (i * 97) & 511, "R4 idle");
        step(1'b1, 0, "R4 history kept");
        check("R4 history kept value", int'(out_sample), 45*511/32 + 41*511/32);

        // R5 mid-run reset clears history.
        do_reset();
        step(1'b1, 300, "R5 first after reset");
        check("R5 first value", int'(out_sample), (41 * 300) >> 5);
        step(1'b1, 100, "R5 second after reset");
        check("R5 second value", int'(out_sample), ((41 * 100) >> 5) + ((45 * 300) >> 5));

        // R2 R3 random samples with gaps.
        for (int i = 0; i < 400; i++) begin
            bit v;
            int d;
            v = ($urandom % 10) < 7;
            d = int'($urandom % 512);
            step(v, d, "R2 R3 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule